// File: doc/BRIEF.md
# Memory-Mapped Peripheral Bus Subsystem

This block terminates a simple processor memory bus (a request valid, a 32-bit address, 32-bit write data, four byte strobes, 32-bit read data and an acknowledge). It steers each request to one of a small set of targets: a word-organised RAM, a one-bit LED register, and an 8-bit PWM duty register. A slot held for a future serial port is also acknowledged. Every request is answered with a single acknowledge pulse. Read data is presented in the same cycle as that pulse.

The PWM generator is part of the block. A free-running counter is compared against the stored duty value, and the result drives the PWM pin directly. Software turns the LED on and sets the brightness by storing to fixed addresses. It can read both settings back.

Top module: `mmio_subsys`

## Requirements
- R1: Address decode is fixed. Any address whose bits 31:16 are zero selects the RAM. Exactly 0x0300_0000 selects the LED register, exactly 0x0300_1000 selects the PWM duty register, and exactly 0x0300_2000 is the reserved serial slot. Every other address is unmapped.
- R2: A request with a nonzero strobe is a write. A request with strobe 4'b0000 is a read.
- R3: The acknowledge goes high in the cycle after valid is first seen and stays high for exactly one cycle. It never rises without a preceding valid. The master holds valid until it sees the acknowledge.
- R4: A RAM write changes only the bytes whose strobe bit is set. Strobe bit n covers data bits 8n+7:8n.
- R5: The RAM is addressed by word using address bits 2 upward. The word index wraps modulo the RAM_DEPTH parameter, so with the default depth of 256, byte address 0x400 reaches the same word as 0x0.
- R6: A write to the LED address stores data bit 0, whatever the strobe pattern, and drives led_o from it. A read returns that bit zero-extended.
- R7: A write to the PWM address stores data bits 7:0 as the duty. A read returns the duty zero-extended.
- R8: Requests to the serial slot or to an unmapped address are acknowledged and read as zero. A write there alters no LED, duty or RAM state.
- R9: pwm_o is high while an 8-bit free-running counter is below the duty. A duty of 0 keeps pwm_o low, and a duty of N gives exactly N high cycles in any 256 consecutive cycles.
- R10: Asserting the active-low asynchronous reset clears the LED register, the duty register, the PWM counter and the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte strobes; zero means read |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | One-cycle acknowledge |
| led_o | output | 1 | LED drive |
| pwm_o | output | 1 | PWM output |

## Verification
A decode fault has one of two visible effects. It lands a store in the wrong place, which a later read-back of RAM, LED or duty exposes within one transaction. Or it returns nonzero data from an empty slot, which the acknowledging read itself shows. A stuck or stretched acknowledge shows up in the very next cycle as ready_o staying high. A bad counter or compare changes how many cycles pwm_o spends high in a 256-cycle window, which is counted exactly for duties at both ends and in the middle. A corrupted duty register also shows on the read-back.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam logic [31:0] LED_ADDR  = 32'h0300_0000;
  localparam logic [31:0] PWM_ADDR  = 32'h0300_1000;
  localparam logic [31:0] UART_ADDR = 32'h0300_2000;

  typedef enum logic [2:0] {
    TGT_RAM,
    TGT_LED,
    TGT_PWM,
    TGT_UART,
    TGT_NONE
  } tgt_e;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
(
  input  logic [31:0] addr_i,
  output tgt_e        tgt_o
);
  always_comb begin
    if (addr_i[31:16] == 16'h0)    tgt_o = TGT_RAM;
    else if (addr_i == LED_ADDR)   tgt_o = TGT_LED;
    else if (addr_i == PWM_ADDR)   tgt_o = TGT_PWM;
    else if (addr_i == UART_ADDR)  tgt_o = TGT_UART;
    else                           tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
  parameter int DEPTH = 256,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [3:0]    wstrb_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      for (int b = 0; b < 4; b++) begin
        if (wstrb_i[b]) mem_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
      rdata_o <= mem_q[idx_i];
    end
  end
endmodule

// File: rtl/mmio_pwm.sv
module mmio_pwm #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign pwm_o = cnt_q < duty_i;
endmodule

// File: rtl/mmio_subsys.sv
module mmio_subsys
  import mmio_pkg::*;
#(
  parameter int RAM_DEPTH = 256,
  parameter int PWM_W     = 8,
  localparam int IW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  wstrb_i,
  output logic [31:0] rdata_o,
  output logic        ready_o,
  output logic        led_o,
  output logic        pwm_o
);
  tgt_e             tgt;
  tgt_e             tgt_q;
  logic             accept;
  logic             is_wr;
  logic             led_q;
  logic [PWM_W-1:0] duty_q;
  logic [31:0]      reg_rdata;
  logic [31:0]      reg_rdata_q;
  logic [31:0]      ram_rdata;

  mmio_decode u_decode (
    .addr_i (addr_i),
    .tgt_o  (tgt)
  );

  // One request accepted per handshake; the ack cycle itself is never accepted.
  assign accept = valid_i && !ready_o;
  assign is_wr  = |wstrb_i;

  mmio_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .en_i    (accept && (tgt == TGT_RAM)),
    .idx_i   (addr_i[IW+1:2]),
    .wstrb_i (wstrb_i),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  mmio_pwm #(.CNT_W(PWM_W)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .duty_i (duty_q),
    .pwm_o  (pwm_o)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (tgt)
      TGT_LED: reg_rdata[0]       = led_q;
      TGT_PWM: reg_rdata[PWM_W-1:0] = duty_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o     <= 1'b0;
      led_q       <= 1'b0;
      duty_q      <= '0;
      tgt_q       <= TGT_NONE;
      reg_rdata_q <= '0;
    end else begin
      ready_o <= accept;
      if (accept) begin
        tgt_q       <= tgt;
        reg_rdata_q <= reg_rdata;
        if (is_wr && tgt == TGT_LED) led_q  <= wdata_i[0];
        if (is_wr && tgt == TGT_PWM) duty_q <= wdata_i[PWM_W-1:0];
      end
    end
  end

  assign rdata_o = (tgt_q == TGT_RAM) ? ram_rdata : reg_rdata_q;
  assign led_o   = led_q;
endmodule

// File: rtl/mmio_subsys_chk.sv
module mmio_subsys_chk #(
  parameter int PWM_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [31:0]      addr_i,
  input logic [3:0]       wstrb_i,
  input logic             ready_o,
  input logic             led_o,
  input logic             pwm_o,
  input logic [PWM_W-1:0] duty_i
);
  logic led_wr;
  logic pwm_wr;
  assign led_wr = valid_i && !ready_o && (wstrb_i != 4'b0) && (addr_i == 32'h0300_0000);
  assign pwm_wr = valid_i && !ready_o && (wstrb_i != 4'b0) && (addr_i == 32'h0300_1000);

  assert_ready_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_ready_needs_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !ready_o);

  assert_led_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !led_wr |=> $stable(led_o));

  assert_duty_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_wr |=> $stable(duty_i));

  assert_duty_zero_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |-> !pwm_o);
endmodule

bind mmio_subsys mmio_subsys_chk #(.PWM_W(PWM_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .addr_i  (addr_i),
  .wstrb_i (wstrb_i),
  .ready_o (ready_o),
  .led_o   (led_o),
  .pwm_o   (pwm_o),
  .duty_i  (duty_q)
);

// File: tb/mmio_subsys_tb.sv
`timescale 1ns/1ps
module mmio_subsys_tb;
  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_0000, 32'hDEAD_BEEF, 4'hF, 32'h0},           // R4
    '{1'b0, 32'h0000_0000, 32'h0,         4'h0, 32'hDEAD_BEEF},   // R1 R2
    '{1'b1, 32'h0000_0004, 32'h1122_3344, 4'hF, 32'h0},
    '{1'b1, 32'h0000_0004, 32'hAABB_CCDD, 4'h5, 32'h0},           // R4 lanes 0,2
    '{1'b0, 32'h0000_0004, 32'h0,         4'h0, 32'h11BB_33DD},   // R4
    '{1'b1, 32'h0000_0400, 32'h5A5A_5A5A, 4'hF, 32'h0},           // R5 alias
    '{1'b0, 32'h0000_0000, 32'h0,         4'h0, 32'h5A5A_5A5A},   // R5
    '{1'b1, 32'h0300_0000, 32'h0000_0003, 4'h2, 32'h0},           // R6 any strobe
    '{1'b0, 32'h0300_0000, 32'h0,         4'h0, 32'h0000_0001},   // R6
    '{1'b1, 32'h0300_1000, 32'h0000_1234, 4'hF, 32'h0},           // R7
    '{1'b0, 32'h0300_1000, 32'h0,         4'h0, 32'h0000_0034},   // R7
    '{1'b1, 32'h0300_2000, 32'hFFFF_FFFF, 4'hF, 32'h0},           // R8
    '{1'b0, 32'h0300_2000, 32'h0,         4'h0, 32'h0},           // R8
    '{1'b1, 32'h0300_0004, 32'hFFFF_FFFF, 4'hF, 32'h0},           // R8 unmapped
    '{1'b1, 32'h0001_0000, 32'h0BAD_0BAD, 4'hF, 32'h0},           // R1 outside RAM
    '{1'b0, 32'h0300_0004, 32'h0,         4'h0, 32'h0},           // R8
    '{1'b0, 32'h0001_0000, 32'h0,         4'h0, 32'h0},           // R1
    '{1'b0, 32'h0300_0000, 32'h0,         4'h0, 32'h0000_0001},   // R8 LED kept
    '{1'b0, 32'h0300_1000, 32'h0,         4'h0, 32'h0000_0034},   // R8 duty kept
    '{1'b0, 32'h0000_0000, 32'h0,         4'h0, 32'h5A5A_5A5A}    // R8 RAM kept
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wstrb_i = '0;
  logic [31:0] rdata_o;
  logic        ready_o;
  logic        led_o;
  logic        pwm_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2.5 clk_i = ~clk_i;

  mmio_subsys u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wstrb_i(wstrb_i), .rdata_o(rdata_o), .ready_o(ready_o),
    .led_o(led_o), .pwm_o(pwm_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, output logic [31:0] r);
    @(negedge clk_i);
    check(ready_o == 1'b0, "R3 idle", {31'b0, ready_o}, 32'h0);
    valid_i = 1'b1; addr_i = a; wdata_i = d; wstrb_i = s;
    @(posedge clk_i); #1;
    check(ready_o == 1'b1, "R3 ack", {31'b0, ready_o}, 32'h1);
    r = rdata_o;
    @(negedge clk_i);
    valid_i = 1'b0; wstrb_i = '0;
    @(posedge clk_i); #1;
    check(ready_o == 1'b0, "R3 pulse", {31'b0, ready_o}, 32'h0);
  endtask

  task automatic count_pwm(input int exp, input string req);
    int highs = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
    end
    check(highs == exp, req, highs, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(ready_o == 1'b0 && led_o == 1'b0 && pwm_o == 1'b0, "R10 reset outputs",
          {29'b0, ready_o, led_o, pwm_o}, 32'h0);
    rst_ni = 1'b1;
    xfer(32'h0300_0000, 32'h0, 4'h0, rd);
    check(rd == 32'h0, "R10 LED after reset", rd, 32'h0);
    xfer(32'h0300_1000, 32'h0, 4'h0, rd);
    check(rd == 32'h0, "R10 duty after reset", rd, 32'h0);
    count_pwm(0, "R9 duty zero after reset");

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].addr, VEC[i].wdata, VEC[i].wr ? VEC[i].strb : 4'h0, rd);
      if (!VEC[i].wr) check(rd == VEC[i].exp, $sformatf("R1/R2 vector %0d", i), rd, VEC[i].exp);
    end

    check(led_o == 1'b1, "R6 led_o driven", {31'b0, led_o}, 32'h1);
    xfer(32'h0300_0000, 32'hFFFF_FFFE, 4'h1, rd);
    check(led_o == 1'b0, "R6 led cleared by bit0", {31'b0, led_o}, 32'h0);

    // R9 duty 0x34 = 52 highs in 256 cycles
    count_pwm(52, "R9 duty 52");
    xfer(32'h0300_1000, 32'h0000_00FF, 4'h1, rd);
    count_pwm(255, "R9 duty 255");
    xfer(32'h0300_1000, 32'h0000_0100, 4'hF, rd);
    count_pwm(0, "R9 duty 0 from bits 7:0");
    xfer(32'h0300_1000, 32'h0000_0001, 4'hF, rd);
    count_pwm(1, "R9 duty 1");

    // R2 read must not write
    xfer(32'h0000_0008, 32'hCAFE_F00D, 4'hF, rd);
    xfer(32'h0000_0008, 32'h1234_5678, 4'h0, rd);
    check(rd == 32'hCAFE_F00D, "R2 read does not store", rd, 32'hCAFE_F00D);

    // R10 reset in operation
    xfer(32'h0300_0000, 32'h1, 4'hF, rd);
    xfer(32'h0300_1000, 32'h80, 4'hF, rd);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check(led_o == 1'b0 && pwm_o == 1'b0, "R10 async clear", {30'b0, led_o, pwm_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    xfer(32'h0300_1000, 32'h0, 4'h0, rd);
    check(rd == 32'h0, "R10 duty cleared", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule